// File: doc/BRIEF.md
# Bidirectional Sampling Pulse Shifter

This block produces the column sampling strobes for one segment of a display column driver. A start pulse enters through one of two cascade pins, is captured on a rising edge of clock phase 1, and then travels as a single active bit along a chain of stages. Each stage drives one sampling pulse output. After the last stage has fired, the pulse leaves through the opposite cascade pin, so several segments can be chained end to end.

A direction input selects which cascade pin accepts the start and which one drives it onward. It also decides whether the pulse sweeps from column 1 upward or from column N downward. A mode input selects between two sampling schemes. In simultaneous sampling, only phase 1 moves the pulse and all three colour channels are sampled together. In successive sampling, a three-phase clock moves the pulse one stage on each phase edge in strict rotation, and each stage samples one colour channel. The three clock phases are not used as clocks: the system clock samples them and their rising edges are detected.

Top module: `sample_pulse_shifter`

## Requirements
- R1: During and after synchronous reset, every sampling pulse output is 0 and both cascade data outputs are 0. The phase rotation restarts at phase 1.
- R2: When `dir_right`=1, a start on `casc_r_in` seen at a phase-1 rising edge sets column 1 (`pulse_out[0]`) in that cycle. Each later advance moves the single active bit one column up.
- R3: When `dir_right`=0, a start on `casc_l_in` sets column N (`pulse_out[N-1]`). Each advance moves the active bit one column down.
- R4: A start level present only at a rising edge of phase 2 or phase 3 is never captured.
- R5: When `seq_mode`=0, the pulse advances exactly once per rising edge of phase 1. Rising edges of phases 2 and 3 leave all outputs unchanged.
- R6: When `seq_mode`=1, the pulse advances on the rising edges of phase 1, phase 2 and phase 3, in that repeating order. A rising edge of a phase that is out of turn changes nothing.
- R7: A start input held high across several phase-1 rising edges loads exactly one pulse. Only the first capture after the start was low counts.
- R8: In the advance that follows the one where the last stage was active, the downstream cascade output goes to 1 and stays there until the next advance. The downstream pin is `casc_l_out` when `dir_right`=1 and `casc_r_out` otherwise. The output enable is 1 on the downstream pin and 0 on the upstream pin, and the upstream data output stays 0. This holds in both modes.
- R9: Once the pulse has passed the last stage, all sampling outputs stay 0 until a new start is captured.
- R10: `chan_mask` bit c is 1 when channel c+1 is being sampled. When `seq_mode`=0, the mask is 3'b111 while any pulse is active. When `seq_mode`=1, chain stage k (counted from 1 in sweep order) selects channel ((k-1) mod 3)+1. The mask is 0 when no pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every other input |
| rst | input | 1 | Synchronous active-high reset |
| dir_right | input | 1 | 1: sweep column 1 to N, start on right pin; 0: mirrored |
| seq_mode | input | 1 | 0: simultaneous sampling; 1: successive three-phase sampling |
| ph_clk | input | 3 | Shift clock phases; bit 0 is phase 1 |
| casc_r_in | input | 1 | Right cascade pin, input side |
| casc_l_in | input | 1 | Left cascade pin, input side |
| casc_r_out | output | 1 | Right cascade pin, data driven out |
| casc_r_oe | output | 1 | Right cascade pin output enable |
| casc_l_out | output | 1 | Left cascade pin, data driven out |
| casc_l_oe | output | 1 | Left cascade pin output enable |
| pulse_out | output | N_COLS | Sampling pulses, bit i is column i+1 |
| chan_mask | output | 3 | Colour channels sampled by the active pulse |

## Verification
The bench builds the block with N_COLS set to 12. With this setting, a full sweep takes a dozen advances, so the end of the chain, the cascade hand-off and the return to zeros are reached many times in both directions and both modes. Twelve is a multiple of three, so the channel rotation wraps cleanly across the chain. The stage that enters from the far end in the mirrored direction is also still distinct from its neighbours. Wide start pulses and out-of-turn phase edges are placed inside live sweeps, where an error would show up as a second bit or a skipped column.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef struct packed {
        logic evt;       // chain advances this cycle
        logic ph1_rise;  // phase 1 rose this cycle
    } step_t;

    typedef struct packed {
        logic dout;
        logic oe;
    } casc_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_A:    return PH_B;
            PH_B:    return PH_C;
            default: return PH_A;
        endcase
    endfunction

endpackage

// File: rtl/spc_phase_track.sv
module spc_phase_track
    import spc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        seq_mode,
    input  logic [2:0]  ph_clk,
    output step_t       step
);

    logic [2:0] ph_prev;
    logic [2:0] rise;
    phase_e     ptr;
    logic       turn_rise;

    assign rise = ph_clk & ~ph_prev;

    always_comb begin
        case (ptr)
            PH_A:    turn_rise = rise[0];
            PH_B:    turn_rise = rise[1];
            PH_C:    turn_rise = rise[2];
            default: turn_rise = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev <= '0;
            ptr     <= PH_A;
        end else begin
            ph_prev <= ph_clk;
            if (!seq_mode)
                ptr <= PH_A;
            else if (turn_rise)
                ptr <= next_phase(ptr);
        end
    end

    assign step.evt      = seq_mode ? turn_rise : rise[0];
    assign step.ph1_rise = rise[0];

    AST_SIMUL_PTR: assert property (@(posedge clk) disable iff (rst)
        !seq_mode |=> (ptr == PH_A)); // R5

endmodule

// File: rtl/spc_start_qual.sv
module spc_start_qual
    import spc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_lvl,
    input  step_t step,
    output logic  load
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= 1'b0;
        else if (step.ph1_rise)
            seen <= start_lvl;
    end

    assign load = step.evt & step.ph1_rise & start_lvl & ~seen;

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> !load); // R7

endmodule

// File: rtl/spc_chain.sv
module spc_chain #(
    parameter int N_COLS = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              load,
    output logic [N_COLS-1:0] stages,
    output logic              carry
);

    localparam int LAST = N_COLS - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
            carry  <= 1'b0;
        end else if (adv) begin
            stages <= {stages[LAST-1:0], load};
            carry  <= stages[LAST];
        end
    end

    AST_HOLD_NO_EVT: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(stages) && $stable(carry))); // R6

    AST_CARRY_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(carry) |-> $past(stages[LAST])); // R8

endmodule

// File: rtl/spc_col_map.sv
module spc_col_map #(
    parameter int N_COLS = 240
) (
    input  logic              dir_right,
    input  logic [N_COLS-1:0] stages,
    output logic [N_COLS-1:0] cols
);

    for (genvar i = 0; i < N_COLS; i++) begin : g_col
        assign cols[i] = dir_right ? stages[i] : stages[N_COLS-1-i];
    end

endmodule

// File: rtl/spc_chan_map.sv
module spc_chan_map
    import spc_pkg::*;
#(
    parameter int N_COLS = 240
) (
    input  logic              seq_mode,
    input  logic [N_COLS-1:0] stages,
    output logic [2:0]        chan_mask
);

    logic [PHASES-1:0][N_COLS-1:0] hit;
    logic [PHASES-1:0]             seq_mask;

    for (genvar c = 0; c < PHASES; c++) begin : g_chan
        for (genvar i = 0; i < N_COLS; i++) begin : g_stage
            if ((i % PHASES) == c) begin : g_on
                assign hit[c][i] = stages[i];
            end else begin : g_off
                assign hit[c][i] = 1'b0;
            end
        end
        assign seq_mask[c] = |hit[c];
    end

    assign chan_mask = seq_mode ? seq_mask : {3{|stages}};

endmodule

// File: rtl/sample_pulse_shifter.sv
module sample_pulse_shifter
    import spc_pkg::*;
#(
    parameter int N_COLS = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_right,
    input  logic              seq_mode,
    input  logic [2:0]        ph_clk,
    input  logic              casc_r_in,
    input  logic              casc_l_in,
    output logic              casc_r_out,
    output logic              casc_r_oe,
    output logic              casc_l_out,
    output logic              casc_l_oe,
    output logic [N_COLS-1:0] pulse_out,
    output logic [2:0]        chan_mask
);

    step_t             step;
    logic              start_lvl;
    logic              load;
    logic [N_COLS-1:0] stages;
    logic              carry;
    casc_t             r_pin;
    casc_t             l_pin;

    assign start_lvl = dir_right ? casc_r_in : casc_l_in;

    spc_phase_track u_phase (
        .clk      (clk),
        .rst      (rst),
        .seq_mode (seq_mode),
        .ph_clk   (ph_clk),
        .step     (step)
    );

    spc_start_qual u_start (
        .clk       (clk),
        .rst       (rst),
        .start_lvl (start_lvl),
        .step      (step),
        .load      (load)
    );

    spc_chain #(.N_COLS(N_COLS)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .adv    (step.evt),
        .load   (load),
        .stages (stages),
        .carry  (carry)
    );

    spc_col_map #(.N_COLS(N_COLS)) u_cols (
        .dir_right (dir_right),
        .stages    (stages),
        .cols      (pulse_out)
    );

    spc_chan_map #(.N_COLS(N_COLS)) u_chan (
        .seq_mode  (seq_mode),
        .stages    (stages),
        .chan_mask (chan_mask)
    );

    assign r_pin.oe   = ~dir_right;
    assign r_pin.dout = ~dir_right & carry;
    assign l_pin.oe   = dir_right;
    assign l_pin.dout = dir_right & carry;

    assign casc_r_out = r_pin.dout;
    assign casc_r_oe  = r_pin.oe;
    assign casc_l_out = l_pin.dout;
    assign casc_l_oe  = l_pin.oe;

    AST_CHAN_ONE: assert property (@(posedge clk) disable iff (rst)
        (seq_mode && $onehot(pulse_out)) |-> $onehot(chan_mask)); // R10

    AST_UPSTREAM_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(casc_r_out && casc_l_out)); // R8

endmodule

// File: tb/sim_sample_pulse_shifter.sv
module sim_sample_pulse_shifter;

    localparam int N = 12;

    typedef struct {
        logic [N-1:0] pulses;
        logic         r_out;
        logic         r_oe;
        logic         l_out;
        logic         l_oe;
        logic [2:0]   mask;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dir_right = 1'b1;
    logic         seq_mode = 1'b0;
    logic [2:0]   ph_clk = 3'b000;
    logic         casc_r_in = 1'b0;
    logic         casc_l_in = 1'b0;
    logic         casc_r_out, casc_r_oe, casc_l_out, casc_l_oe;
    logic [N-1:0] pulse_out;
    logic [2:0]   chan_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exp_t q[$];
    event chk_ev;

    logic [N-1:0] m_chain;
    logic         m_carry;
    logic         m_seen;
    int           m_ptr;

    always #2.5 clk = ~clk;

    sample_pulse_shifter #(.N_COLS(N)) u0 (
        .clk(clk), .rst(rst), .dir_right(dir_right), .seq_mode(seq_mode),
        .ph_clk(ph_clk), .casc_r_in(casc_r_in), .casc_l_in(casc_l_in),
        .casc_r_out(casc_r_out), .casc_r_oe(casc_r_oe),
        .casc_l_out(casc_l_out), .casc_l_oe(casc_l_oe),
        .pulse_out(pulse_out), .chan_mask(chan_mask)
    );

    function automatic exp_t expect_now(string tag);
        exp_t e;
        logic [2:0] mk = 3'b000;
        for (int i = 0; i < N; i++) begin
            e.pulses[i] = dir_right ? m_chain[i] : m_chain[N-1-i];
            if (m_chain[i]) mk[i % 3] = 1'b1;
        end
        if (!seq_mode) mk = (m_chain != '0) ? 3'b111 : 3'b000;
        e.mask  = mk;
        e.l_oe  = dir_right;
        e.r_oe  = !dir_right;
        e.l_out = dir_right & m_carry;
        e.r_out = !dir_right & m_carry;
        e.tag   = tag;
        return e;
    endfunction

    task automatic model_rise(int p);
        bit evt;
        bit ld = 1'b0;
        bit st = dir_right ? casc_r_in : casc_l_in;
        evt = seq_mode ? (p == m_ptr) : (p == 0);
        if (p == 0) begin
            ld = evt && st && !m_seen;
            m_seen = st;
        end
        if (evt) begin
            m_carry = m_chain[N-1];
            m_chain = {m_chain[N-2:0], ld};
            if (seq_mode) m_ptr = (m_ptr + 1) % 3;
        end
    endtask

    task automatic push_check(string tag);
        q.push_back(expect_now(tag));
        -> chk_ev;
    endtask

    task automatic step(int p, string tag);
        @(negedge clk);
        ph_clk[p] = 1'b1;
        model_rise(p);
        @(negedge clk);
        push_check(tag);
        ph_clk[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(bit dr, bit sm);
        @(negedge clk);
        rst = 1'b1;
        dir_right = dr;
        seq_mode = sm;
        ph_clk = 3'b000;
        casc_r_in = 1'b0;
        casc_l_in = 1'b0;
        m_chain = '0;
        m_carry = 1'b0;
        m_seen = 1'b0;
        m_ptr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        push_check("R1 reset state");
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(chk_ev);
            begin
                exp_t e;
                e = q.pop_front();
                n_tests++;
                if (pulse_out !== e.pulses || chan_mask !== e.mask ||
                    casc_r_out !== e.r_out || casc_r_oe !== e.r_oe ||
                    casc_l_out !== e.l_out || casc_l_oe !== e.l_oe) begin
                    n_fail++;
                    $display("FAIL %s: pulses=%b mask=%b r=%b/%b l=%b/%b expected pulses=%b mask=%b r=%b/%b l=%b/%b",
                             e.tag, pulse_out, chan_mask, casc_r_out, casc_r_oe,
                             casc_l_out, casc_l_oe, e.pulses, e.mask,
                             e.r_out, e.r_oe, e.l_out, e.l_oe);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // simultaneous, right shift
        do_reset(1'b1, 1'b0);
        casc_r_in = 1'b1;
        step(1, "R4 start at phase 2 edge not captured");
        step(2, "R4 start at phase 3 edge not captured");
        step(0, "R2 start captured into column 1");
        casc_r_in = 1'b0;
        step(0, "R2 advance to column 2");
        step(1, "R5 phase 2 ignored in simultaneous mode");
        step(2, "R5 phase 3 ignored in simultaneous mode");
        for (int k = 2; k < N; k++) step(0, "R5 advance one column per phase 1");
        step(0, "R8 cascade out after last stage");
        step(1, "R8 cascade held between advances");
        step(0, "R9 chain empty after sweep");
        step(0, "R9 chain stays empty");

        // wide start pulse
        casc_r_in = 1'b1;
        step(0, "R7 wide start first capture");
        step(0, "R7 wide start no second pulse");
        step(0, "R7 wide start still one pulse");
        casc_r_in = 1'b0;
        step(0, "R7 single pulse continues");
        casc_r_in = 1'b1;
        step(0, "R7 new start after low loads");
        casc_r_in = 1'b0;
        for (int k = 0; k < N; k++) step(0, "R2 two pulses sweep right");

        // simultaneous, left shift
        do_reset(1'b0, 1'b0);
        casc_r_in = 1'b1;
        step(0, "R3 right pin ignored in left shift");
        casc_r_in = 1'b0;
        step(0, "R3 clear seen");
        casc_l_in = 1'b1;
        step(0, "R3 start captured into column N");
        casc_l_in = 1'b0;
        for (int k = 1; k < N; k++) step(0, "R3 advance downward");
        step(0, "R8 left shift cascade on right pin");
        step(0, "R9 left shift chain empty");

        // successive, right shift
        do_reset(1'b1, 1'b1);
        step(1, "R1 rotation restarts at phase 1");
        casc_r_in = 1'b1;
        step(0, "R6 start captured on phase 1");
        casc_r_in = 1'b0;
        step(1, "R10 channel 2 on stage 2");
        step(1, "R6 repeated phase 2 out of turn");
        step(0, "R6 phase 1 out of turn");
        step(2, "R10 channel 3 on stage 3");
        for (int k = 3; k < N; k++) step(k % 3, "R6 three-phase rotation");
        step(0, "R8 successive cascade out");
        step(1, "R9 successive chain empty");
        step(2, "R9 successive stays empty");

        // successive, left shift
        do_reset(1'b0, 1'b1);
        casc_l_in = 1'b1;
        step(0, "R3 successive left start");
        casc_l_in = 1'b0;
        for (int k = 1; k <= N; k++) step(k % 3, "R10 successive left sweep");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule